// File: doc/BRIEF.md
# Cross-Link Fault Status Register

This block is the fault status and control register of a two-zone (A/B) cross-link interconnect. Fault events from the link, the clock and halt monitors and the memory ECC checkers are captured into sticky status bits. Software reads these bits and clears them by writing ones. The block raises a module-fail request per zone whenever that zone's memory-write ECC check trips. It also produces one interrupt line.

A control word holds the 3-bit link mode and an error-enable flag. The block protects the mode field against illegal states. A lost cable or a lost peer supply forces the link off and blocks mode writes. A fault during resynchronisation drops the link out of resync on the same edge that records the fault. Level-type sources re-assert their bit for as long as the line stays high, so a clear cannot hide a fault that is still present. The register port is a plain single-cycle access with a combinational read, and every event input is sampled on each clock edge.

Top module: `lfr_top`

## Requirements
- R1: After reset (rst_n low at a clock edge) the status word, the control word and `link_mode_o` read zero (mode 000 = off), and `irq_o` and `mod_fail_o` are low.
- R2: Status bits 21/20 (clock-phase fault, zone B/A) and 19/18 (halt request, zone B/A) set while their input is high. They stay set after the input falls until a write to the status address (addr 0) with a 1 in that bit position. Writing 0 to any status bit leaves it unchanged.
- R3: A write-one clear of a bit whose source is asserted in the same cycle leaves the bit set, so a level still high after the clear reads back 1.
- R4: A memory-write ECC fault on zone B (`wr_ecc_err_i[1]`) sets status bits 15 and 17. On zone A (`wr_ecc_err_i[0]`) it sets bits 14 and 16. `mod_fail_o` equals {bit 17, bit 16}.
- R5: Status bit 13 sets when `rd_sbe_b_i` is high and `rd_self_i` is low, whatever the error-enable state. It does not set when `rd_self_i` is high.
- R6: Status bit 25 latches `ilk_err_i`. Status bits 31:26 and 12:0 always read 0.
- R7: The control word (addr 1) holds the mode in bits 2:0 and error-enable in bit 3. Mode 101 is resync slave, 110 is resync master and 000 is off. A write of mode 111 leaves the mode unchanged but still updates error-enable.
- R8: `link_err_i` while the mode is 101 or 110 sets status bit 24 and sets the mode to 000 on the same edge. This takes priority over a simultaneous control write. `link_err_i` in any other mode has no effect.
- R9: Status bit 23 latches `cable_gone_i` and bit 22 latches `peer_pwr_gone_i`. While either bit is set, the mode reads 000 from the following cycle onward, and mode writes are ignored.
- R10: `irq_o` is registered. One cycle after the status word holds bit 13, or holds any of bits 25:14 while error-enable is 1, `irq_o` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = status, 1 = control |
| reg_wdata_i | input | 32 | Write data (ones clear status bits) |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| ilk_err_i | input | 1 | Fault during interlocked I/O access |
| link_err_i | input | 1 | Link fault (aborts resync) |
| cable_gone_i | input | 1 | Cable loss detected |
| peer_pwr_gone_i | input | 1 | Other zone's power lost |
| clk_phase_err_i | input | 2 | Clock-phase fault level, [1]=B, [0]=A |
| halt_req_i | input | 2 | Halt request level, [1]=B, [0]=A |
| wr_ecc_err_i | input | 2 | Memory-write ECC fault, [1]=B, [0]=A |
| rd_sbe_b_i | input | 1 | Zone B single-bit read error |
| rd_self_i | input | 1 | This node requested the read data |
| link_mode_o | output | 3 | Current link mode |
| mod_fail_o | output | 2 | Module-fail request, [1]=B, [0]=A |
| irq_o | output | 1 | Interrupt request |

## Verification
Two kinds of collision can fall in one cycle. A software write-one clear can meet a fresh event on the same bit. A resync-aborting link fault can meet a control write of a new mode. The bench drives the event and the register write in the same cycle window. It then reads the status word and `link_mode_o` one edge later, and it expects the event and the abort to win. The timing of the mode override after cable loss and the timing of the registered interrupt are each judged cycle by cycle.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  localparam int REG_W = 32;

  localparam int B_ILK    = 25;
  localparam int B_RSA    = 24;
  localparam int B_CABLE  = 23;
  localparam int B_PWR    = 22;
  localparam int B_CPH_B  = 21;
  localparam int B_CPH_A  = 20;
  localparam int B_HLT_B  = 19;
  localparam int B_HLT_A  = 18;
  localparam int B_MF_B   = 17;
  localparam int B_MF_A   = 16;
  localparam int B_WE_B   = 15;
  localparam int B_WE_A   = 14;
  localparam int B_RSBE   = 13;

  // bits that hold state
  localparam logic [REG_W-1:0] STAT_IMPL = 32'h03FF_E000;
  // bits whose interrupt contribution is gated by error-enable
  localparam logic [REG_W-1:0] STAT_GATED = 32'h03FF_C000;

  localparam int MODE_W = 3;
  localparam int CTRL_EN_BIT = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF       = 3'b000,
    MODE_RS_SLAVE  = 3'b101,
    MODE_RS_MASTER = 3'b110,
    MODE_BAD       = 3'b111
  } link_mode_e;

  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/lfr_sticky_bank.sv
module lfr_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // event beats clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;

      assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q_o[i]);
      assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o[i] && !clr_i[i]) |=> q_o[i]);
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/lfr_mode_ctl.sv
module lfr_mode_ctl
  import lfr_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [MW-1:0] wmode_i,
  input  logic          link_down_i,
  input  logic          abort_i,
  output logic [MW-1:0] mode_o
);
  logic [MW-1:0] mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (link_down_i)                         mode_d = MODE_OFF;
    else if (abort_i)                        mode_d = MODE_OFF;
    else if (wr_i && wmode_i != MODE_BAD)    mode_d = wmode_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != MODE_BAD);
  assert_down_forces_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_down_i |=> mode_o == MODE_OFF);
  assert_abort_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> mode_o == MODE_OFF);
endmodule

// File: rtl/lfr_irq_gen.sv
module lfr_irq_gen
  import lfr_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic         en_i,
  output logic         irq_o
);
  logic irq_q;
  logic gated_any;

  assign gated_any = |(stat_i & STAT_GATED);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= stat_i[B_RSBE] | (en_i & gated_any);
  end

  assign irq_o = irq_q;

  assert_sbe_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_i[B_RSBE] |=> irq_o);
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == '0) |=> !irq_o);
endmodule

// File: rtl/lfr_top.sv
module lfr_top
  import lfr_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic          reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  input  logic          ilk_err_i,
  input  logic          link_err_i,
  input  logic          cable_gone_i,
  input  logic          peer_pwr_gone_i,
  input  logic [1:0]    clk_phase_err_i,
  input  logic [1:0]    halt_req_i,
  input  logic [1:0]    wr_ecc_err_i,
  input  logic          rd_sbe_b_i,
  input  logic          rd_self_i,
  output logic [MW-1:0] link_mode_o,
  output logic [1:0]    mod_fail_o,
  output logic          irq_o
);
  logic [W-1:0] set_vec, clr_vec, stat;
  logic         in_resync, abort, link_down;
  logic         wr_stat, wr_ctrl;
  logic         err_en_q;

  assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);

  assign in_resync = (link_mode_o == MODE_RS_SLAVE) || (link_mode_o == MODE_RS_MASTER);
  assign abort     = link_err_i && in_resync;
  assign link_down = stat[B_CABLE] | stat[B_PWR];

  always_comb begin
    set_vec          = '0;
    set_vec[B_ILK]   = ilk_err_i;
    set_vec[B_RSA]   = abort;
    set_vec[B_CABLE] = cable_gone_i;
    set_vec[B_PWR]   = peer_pwr_gone_i;
    set_vec[B_CPH_B] = clk_phase_err_i[1];
    set_vec[B_CPH_A] = clk_phase_err_i[0];
    set_vec[B_HLT_B] = halt_req_i[1];
    set_vec[B_HLT_A] = halt_req_i[0];
    set_vec[B_MF_B]  = wr_ecc_err_i[1];
    set_vec[B_MF_A]  = wr_ecc_err_i[0];
    set_vec[B_WE_B]  = wr_ecc_err_i[1];
    set_vec[B_WE_A]  = wr_ecc_err_i[0];
    set_vec[B_RSBE]  = rd_sbe_b_i & ~rd_self_i;
  end

  assign clr_vec = wr_stat ? reg_wdata_i : '0;

  lfr_sticky_bank #(.W(W), .IMPL(STAT_IMPL)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(stat)
  );

  lfr_mode_ctl #(.MW(MW)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl && !link_down),
    .wmode_i(reg_wdata_i[MW-1:0]), .link_down_i(link_down),
    .abort_i(abort), .mode_o(link_mode_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       err_en_q <= 1'b0;
    else if (wr_ctrl) err_en_q <= reg_wdata_i[CTRL_EN_BIT];
  end

  lfr_irq_gen #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat_i(stat), .en_i(err_en_q), .irq_o(irq_o)
  );

  assign mod_fail_o = {stat[B_MF_B], stat[B_MF_A]};

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_STAT) begin
      reg_rdata_o = stat;
    end else begin
      reg_rdata_o[MW-1:0]      = link_mode_o;
      reg_rdata_o[CTRL_EN_BIT] = err_en_q;
    end
  end

  assert_rsbe_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sbe_b_i && !rd_self_i) |=> stat[B_RSBE]);
  assert_ecc_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ecc_err_i[1] |=> mod_fail_o[1] && stat[B_WE_B]);
  assert_mode_write_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_down && !abort) |=> link_mode_o == MODE_OFF);
  always_comb begin
    assert_unused_zero_R6: assert ((stat & ~STAT_IMPL) == '0);
  end
endmodule

// File: tb/lfr_top_tb_top.sv
module lfr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ilk = 0, lerr = 0, cable = 0, pwr = 0;
  logic [1:0]  cph = 0, hlt = 0, ecc = 0;
  logic        sbe = 0, self_rd = 0;
  logic [2:0]  mode;
  logic [1:0]  mfail;
  logic        irq;

  always #5 clk = ~clk;

  lfr_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ilk_err_i(ilk),
    .link_err_i(lerr), .cable_gone_i(cable), .peer_pwr_gone_i(pwr),
    .clk_phase_err_i(cph), .halt_req_i(hlt), .wr_ecc_err_i(ecc),
    .rd_sbe_b_i(sbe), .rd_self_i(self_rd), .link_mode_o(mode),
    .mod_fail_o(mfail), .irq_o(irq)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 mode, 2 irq, 3 fail
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: compare all queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {29'b0, mode};
        2: act = {31'b0, irq};
        default: act = {30'b0, mfail};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic sync(); @(negedge clk); #1; endtask
  task automatic push(int k, logic [31:0] e, string t);
    item_t it; it.kind = k; it.exp = e; it.tag = t; q.push_back(it);
  endtask
  task automatic chk_reg(logic a, logic [31:0] e, string t);
    reg_addr = a; push(0, e, t);
  endtask
  task automatic wr(logic a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick(); tick(); tick(); rst_n = 1;
    // R1
    chk_reg(0, 0, "R1 status"); push(1, 0, "R1 mode"); push(2, 0, "R1 irq");
    push(3, 0, "R1 fail"); sync();
    chk_reg(1, 0, "R1 ctrl"); sync();
    // R2: pulse on clock phase A, hold, write 0 no effect, write 1 clears
    cph = 2'b01; tick(); cph = 0; tick();
    chk_reg(0, 32'h0010_0000, "R2 cph_a latched"); sync();
    wr(0, 32'h0); chk_reg(0, 32'h0010_0000, "R2 write0 no effect"); sync();
    wr(0, 32'h0010_0000); chk_reg(0, 0, "R2 cleared"); sync();
    hlt = 2'b10; tick(); hlt = 0; tick();
    chk_reg(0, 32'h0008_0000, "R2 halt_b latched"); sync();
    wr(0, 32'h0008_0000); chk_reg(0, 0, "R2 halt_b cleared"); sync();
    // R3: clear while level high, then event same cycle as clear
    hlt = 2'b01; tick(); wr(0, 32'h0004_0000);
    chk_reg(0, 32'h0004_0000, "R3 level still high"); sync();
    hlt = 0; wr(0, 32'h0004_0000); chk_reg(0, 0, "R3 cleared after drop"); sync();
    cph = 2'b10; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0020_0000; tick();
    reg_wr = 0; cph = 0;
    chk_reg(0, 32'h0020_0000, "R3 event beats clear"); sync();
    wr(0, 32'h0020_0000); chk_reg(0, 0, "R3 clear done"); sync();
    // R4
    ecc = 2'b10; tick(); ecc = 0;
    chk_reg(0, 32'h0002_8000, "R4 zone B"); push(3, 2, "R4 fail B"); sync();
    ecc = 2'b01; tick(); ecc = 0;
    chk_reg(0, 32'h0003_C000, "R4 both zones"); push(3, 3, "R4 fail AB"); sync();
    wr(0, 32'hFFFF_FFFF); tick();
    chk_reg(0, 0, "R4 clear"); push(3, 0, "R4 fail clear"); sync();
    // R5 / R10
    sbe = 1; self_rd = 1; tick(); sbe = 0; self_rd = 0; tick();
    chk_reg(0, 0, "R5 self requester ignored"); push(2, 0, "R5 no irq"); sync();
    sbe = 1; tick(); sbe = 0;
    chk_reg(0, 32'h0000_2000, "R5 sbe latched"); push(2, 0, "R10 irq one cycle later"); sync();
    tick(); push(2, 1, "R10 irq asserted"); sync();
    wr(0, 32'h0000_2000); tick(); push(2, 0, "R10 irq drops"); sync();
    // R6 / R10 gating
    ilk = 1; tick(); ilk = 0; tick();
    chk_reg(0, 32'h0200_0000, "R6 ilk latched"); push(2, 0, "R10 gated off"); sync();
    wr(0, 32'hFC00_1FFF); chk_reg(0, 32'h0200_0000, "R6 unused bits zero"); sync();
    wr(1, 32'h8); tick(); push(2, 1, "R10 gated on"); sync();
    wr(0, 32'h0200_0000); tick(); tick(); push(2, 0, "R10 cleared"); sync();
    // R7
    wr(1, 32'hD); chk_reg(1, 32'hD, "R7 resync slave"); push(1, 5, "R7 mode 101"); sync();
    wr(1, 32'h7); chk_reg(1, 32'h5, "R7 111 rejected"); sync();
    wr(1, 32'h6); push(1, 6, "R7 resync master"); sync();
    wr(1, 32'h2); push(1, 2, "R7 normal mode"); sync();
    // R8
    lerr = 1; tick(); lerr = 0;
    chk_reg(0, 0, "R8 no abort outside resync"); push(1, 2, "R8 mode kept"); sync();
    wr(1, 32'h5); lerr = 1; tick(); lerr = 0;
    chk_reg(0, 32'h0100_0000, "R8 abort latched"); push(1, 0, "R8 mode off"); sync();
    wr(0, 32'h0100_0000);
    wr(1, 32'h6);
    lerr = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 32'h5; tick(); reg_wr = 0; lerr = 0;
    push(1, 0, "R8 abort beats write"); chk_reg(0, 32'h0100_0000, "R8 abort bit"); sync();
    wr(0, 32'h0100_0000);
    // R9
    wr(1, 32'h3);
    cable = 1; tick(); cable = 0;
    chk_reg(0, 32'h0080_0000, "R9 cable latched"); push(1, 3, "R9 mode not yet off"); sync();
    tick(); push(1, 0, "R9 mode forced off"); sync();
    wr(1, 32'h4); push(1, 0, "R9 write ignored"); sync();
    wr(0, 32'h0080_0000); wr(1, 32'h4); push(1, 4, "R9 write after clear"); sync();
    pwr = 1; tick(); tick();
    wr(0, 32'h0040_0000);
    chk_reg(0, 32'h0040_0000, "R3 R9 power level re-sets"); push(1, 0, "R9 pwr off"); sync();
    pwr = 0; wr(0, 32'h0040_0000); wr(1, 32'h1);
    chk_reg(0, 0, "R9 pwr cleared"); push(1, 1, "R9 mode restored"); sync();
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule